// File: doc/BRIEF.md
# Word Address Counter for a Serial Memory Slave

This block holds the word pointer of a two-wire serial memory slave. The pointer has two parts. The low eight bits select a byte within a 256-byte bank. Zero to three bank-select bits sit above them, and these come from the device-select byte. The protocol engine loads each part with its own strobe when those bytes arrive. It pulses a step strobe after every byte that is transferred.

How the pointer advances depends on the direction of the transfer. A read step adds one across the whole pointer, so a long sequential read passes through every bank and then returns to zero. A write step advances only the low four bits, so a burst of writes wraps inside its own 16-byte page. Either kind of step leaves the pointer one past the word just accessed, which is the address a later current-address read uses.

The block also keeps a four-bit slot index that counts the bytes of a write burst. The page buffer uses it to place each byte. Loading a new word address clears the slot index to zero. The bank width is set by the parameter `BLK_BITS` (0 to 3), which gives pointers of 8, 9, 10 or 11 bits.

Top module: `word_addr_ctr`

The control decode reduces the strobes to one operation per cycle:
- **OP_HOLD**: no strobe is active.
- **OP_LOAD**: either load strobe is active. Loads take priority over a step.
- **OP_RD_STEP**: step is active and the direction flag is 1.
- **OP_WR_STEP**: step is active and the direction flag is 0.

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `addr` and `slot` read 0.
- R2: A word load writes `word_byte` into `addr[7:0]`, leaves the bank bits unchanged, and clears `slot` to 0.
- R3: A bank load writes `blk_sel[BLK_BITS-1:0]` into `addr[AW-1:8]` and leaves `addr[7:0]` unchanged. The bits of `blk_sel` at and above `BLK_BITS` have no effect.
- R4: Both loads may be applied in the same cycle. If a load and a step occur in the same cycle, the step is ignored.
- R5: A read step (`step`=1, `rd_mode`=1) sets `addr` to (`addr`+1) mod 2^AW. From the top address it wraps to 0.
- R6: A write step (`step`=1, `rd_mode`=0) adds 1 modulo 16 to `addr[3:0]` and leaves `addr[AW-1:4]` unchanged.
- R7: A write step adds 1 modulo 16 to `slot`. A read step leaves `slot` unchanged.
- R8: With no strobe active, `addr` and `slot` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_ld | input | 1 | Load the bank-select part of the pointer |
| blk_sel | input | 3 | Bank-select bits from the device-select byte |
| word_ld | input | 1 | Load the in-bank word address |
| word_byte | input | 8 | Received word address byte |
| step | input | 1 | A byte was transferred; advance the pointer |
| rd_mode | input | 1 | 1 = read transfer, 0 = write transfer |
| addr | output | AW | Current word pointer (AW = 8 + BLK_BITS) |
| slot | output | 4 | Byte slot index within the write burst |

## Verification
Every strobe takes effect at the rising edge where it is sampled, and the new `addr` and `slot` values appear one edge later with no extra pipeline stage. The bench changes its inputs on the falling edge and updates its arithmetic model at the same moment. It then compares both outputs on the next falling edge, so each result is read exactly one cycle after its stimulus. A second instance with a one-bit bank field runs from the same stimulus. It shows the ignored upper bank bits and the earlier wrap point of a smaller array.

// File: rtl/wac_pkg.sv
package wac_pkg;

    // One operation per cycle, chosen by the decode stage
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_LOAD    = 2'd1,
        OP_RD_STEP = 2'd2,
        OP_WR_STEP = 2'd3
    } op_e;

    localparam int unsigned WORD_BITS = 8;
    localparam int unsigned PAGE_BITS = 4;
    localparam int unsigned SEL_BITS  = 3;

endpackage

// File: rtl/wac_decode.sv
module wac_decode
    import wac_pkg::*;
(
    input  logic blk_ld,
    input  logic word_ld,
    input  logic step,
    input  logic rd_mode,
    output op_e  op
);

    always_comb begin
        if (blk_ld || word_ld) begin
            op = OP_LOAD;
        end else if (step) begin
            op = rd_mode ? OP_RD_STEP : OP_WR_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/wac_next.sv
module wac_next
    import wac_pkg::*;
#(
    parameter int unsigned BLK_BITS = 3,
    localparam int unsigned AW      = WORD_BITS + BLK_BITS
) (
    input  op_e                  op,
    input  logic [AW-1:0]        cur,
    input  logic                 blk_ld,
    input  logic [SEL_BITS-1:0]  blk_sel,
    input  logic                 word_ld,
    input  logic [WORD_BITS-1:0] word_byte,
    output logic [AW-1:0]        nxt
);

    logic [AW-1:0] with_blk;

    generate
        if (BLK_BITS > 0) begin : g_bank
            assign with_blk = {blk_sel[BLK_BITS-1:0], cur[WORD_BITS-1:0]};
        end else begin : g_nobank
            logic unused_sel;
            assign unused_sel = ^blk_sel;
            assign with_blk   = cur;
        end
    endgenerate

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_HOLD: nxt = cur;
            OP_LOAD: begin
                nxt = blk_ld ? with_blk : cur;
                if (word_ld) begin
                    nxt[WORD_BITS-1:0] = word_byte;
                end
            end
            OP_RD_STEP: nxt = cur + AW'(1);
            OP_WR_STEP: nxt = {cur[AW-1:PAGE_BITS], cur[PAGE_BITS-1:0] + PAGE_BITS'(1)};
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
    import wac_pkg::*;
#(
    parameter int unsigned BLK_BITS = 3,
    localparam int unsigned AW      = WORD_BITS + BLK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 blk_ld,
    input  logic [2:0]           blk_sel,
    input  logic                 word_ld,
    input  logic [7:0]           word_byte,
    input  logic                 step,
    input  logic                 rd_mode,
    output logic [AW-1:0]        addr,
    output logic [3:0]           slot
);

    op_e                  op;
    logic [AW-1:0]        addr_q, addr_d;
    logic [PAGE_BITS-1:0] slot_q, slot_d;

    wac_decode u_dec (
        .blk_ld  (blk_ld),
        .word_ld (word_ld),
        .step    (step),
        .rd_mode (rd_mode),
        .op      (op)
    );

    wac_next #(.BLK_BITS(BLK_BITS)) u_nxt (
        .op        (op),
        .cur       (addr_q),
        .blk_ld    (blk_ld),
        .blk_sel   (blk_sel),
        .word_ld   (word_ld),
        .word_byte (word_byte),
        .nxt       (addr_d)
    );

    always_comb begin
        slot_d = slot_q;
        unique case (op)
            OP_LOAD:    slot_d = word_ld ? '0 : slot_q;
            OP_WR_STEP: slot_d = slot_q + PAGE_BITS'(1);
            OP_RD_STEP: slot_d = slot_q;
            OP_HOLD:    slot_d = slot_q;
            default:    slot_d = slot_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            slot_q <= '0;
        end else begin
            addr_q <= addr_d;
            slot_q <= slot_d;
        end
    end

    assign addr = addr_q;
    assign slot = slot_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |=> (addr_q == '0) && (slot_q == '0));

    // R2
    word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ld |=> (addr_q[7:0] == $past(word_byte)) && (slot_q == '0));

    // R5
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_STEP) |=> addr_q == $past(addr_q) + AW'(1));

    // R6
    wr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR_STEP) |=> (addr_q[AW-1:4] == $past(addr_q[AW-1:4]))
                            && (addr_q[3:0] == $past(addr_q[3:0]) + 4'd1));

    // R7
    rd_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD_STEP) |=> $stable(slot_q));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_ld && !word_ld && !step) |=> $stable(addr_q) && $stable(slot_q));

endmodule

// File: tb/word_addr_ctr_tb.sv
`timescale 1ns/1ps
module word_addr_ctr_tb;

    localparam int AW  = 11;
    localparam int AW1 = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_ld = 1'b0;
    logic [2:0] blk_sel = '0;
    logic word_ld = 1'b0;
    logic [7:0] word_byte = '0;
    logic step = 1'b0;
    logic rd_mode = 1'b0;
    logic [AW-1:0]  addr;
    logic [AW1-1:0] addr1;
    logic [3:0] slot, slot1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int exp_a;
    int exp_a1;
    int exp_s;

    always #4 clk = ~clk;

    word_addr_ctr #(.BLK_BITS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .blk_ld(blk_ld), .blk_sel(blk_sel),
        .word_ld(word_ld), .word_byte(word_byte), .step(step), .rd_mode(rd_mode),
        .addr(addr), .slot(slot)
    );

    word_addr_ctr #(.BLK_BITS(1)) u_dut_b1 (
        .clk(clk), .rst_n(rst_n), .blk_ld(blk_ld), .blk_sel(blk_sel),
        .word_ld(word_ld), .word_byte(word_byte), .step(step), .rd_mode(rd_mode),
        .addr(addr1), .slot(slot1)
    );

    task automatic check(input string tag);
        checks++;
        if (int'(addr) != exp_a || int'(slot) != exp_s) begin
            errors++;
            $display("FAIL %s: addr=%0h slot=%0d expected addr=%0h slot=%0d",
                     tag, addr, slot, exp_a, exp_s);
        end
        checks++;
        if (int'(addr1) != exp_a1 || int'(slot1) != exp_s) begin
            errors++;
            $display("FAIL %s (one bank bit): addr=%0h slot=%0d expected addr=%0h slot=%0d",
                     tag, addr1, slot1, exp_a1, exp_s);
        end
    endtask

    task automatic cyc(input bit bl, input int bb, input bit wl, input int wb,
                       input bit st, input bit rd, input string tag);
        blk_ld = bl; blk_sel = 3'(bb); word_ld = wl; word_byte = 8'(wb);
        step = st; rd_mode = rd;
        if (bl || wl) begin
            if (bl) begin
                exp_a  = (exp_a % 256)  + (bb % 8) * 256;
                exp_a1 = (exp_a1 % 256) + (bb % 2) * 256;
            end
            if (wl) begin
                exp_a  = exp_a  - (exp_a % 256)  + wb;
                exp_a1 = exp_a1 - (exp_a1 % 256) + wb;
                exp_s  = 0;
            end
        end else if (st) begin
            if (rd) begin
                exp_a  = (exp_a + 1) % 2048;
                exp_a1 = (exp_a1 + 1) % 512;
            end else begin
                exp_a  = exp_a  - (exp_a % 16)  + ((exp_a + 1) % 16);
                exp_a1 = exp_a1 - (exp_a1 % 16) + ((exp_a1 + 1) % 16);
                exp_s  = (exp_s + 1) % 16;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_a = 0; exp_a1 = 0; exp_s = 0;
        repeat (3) @(negedge clk);
        check("R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle after reset");

        // R2 R3 R4 R5 R6: sweep every bank and word
        for (int b = 0; b < 8; b++) begin
            for (int w = 0; w < 256; w++) begin
                cyc(1, b, 1, w, 0, 0, "R2/R3/R4 dual load");
                cyc(0, 0, 0, 0, 1, 1, "R5 read step");
                cyc(0, 0, 0, 0, 1, 0, "R6/R7 write step");
            end
        end

        // R3: bank load alone keeps the low byte; upper select bits ignored on 1-bit instance
        cyc(0, 0, 1, 8'h5A, 0, 0, "R2 word load");
        cyc(1, 6, 0, 0, 0, 0, "R3 bank load, bit2/bit1 ignored on narrow");
        cyc(1, 3, 0, 0, 0, 0, "R3 bank load");

        // R4: load with step in the same cycle; step ignored
        cyc(0, 0, 1, 8'h10, 1, 1, "R4 load beats read step");
        cyc(0, 0, 1, 8'h20, 1, 0, "R4 load beats write step");
        cyc(1, 2, 0, 0, 1, 1, "R4 bank load beats step");

        // R8: idle holds
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R8 hold");

        // R6 R7: long page write burst from 0x3C wraps within page, slot wraps
        cyc(1, 5, 1, 8'h3C, 0, 0, "R2 load before burst");
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 0, "R6/R7 page write burst");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 1, "R7 read keeps slot");

        // R5: full sequential read over the whole array with wraparound
        cyc(1, 0, 1, 0, 0, 0, "R2 load zero");
        for (int i = 0; i < 2049; i++) cyc(0, 0, 0, 0, 1, 1, "R5 sequential read wrap");
        cyc(1, 7, 1, 8'hFF, 0, 0, "R3 load top");
        cyc(0, 0, 0, 0, 1, 1, "R5 top wraps to zero");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule